// File: doc/BRIEF.md
# PCI initiator transaction sequencer

This block is the bus-master side of a 32-bit multiplexed address/data bus in the PCI style. A local client hands it one request: an address, a bus command, a direction, and a beat count. The block then runs the transaction on the bus. It drives the frame and initiator-ready strobes, the address/data lines with their output enable, and the command/byte-enable lines. It watches the target's device-select and target-ready inputs.

Write beats are pulled from the local side one at a time. A `wr_pop` strobe marks each cycle in which the presented beat is taken. Read beats come back on `rd_data` with a `rd_valid` strobe. When the bus has returned to idle, a one-cycle `done` pulse closes the request. `aborted` accompanies `done` when no target claimed the cycle. In that case the bus is closed in two steps and a read returns all-ones.

All bus strobes are active-high at this boundary; pad inversion lives outside the block. Byte-enable bits are active-high as well (1 = lane enabled).

Top module: `pcis_initiator`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The following cycle is the address phase: `bus_frame` is asserted, `bus_irdy` is negated, `bus_ad_oe` is high, `bus_ad_o` carries `req_addr` and `bus_cbe` carries `req_cmd`, for exactly one cycle.
- R2: For a write, the first data phase follows the address phase directly. In data phase k, `bus_ad_oe` is high, `bus_ad_o` carries beat k's data and `bus_cbe` carries beat k's byte enables. `wr_pop` is high in the address cycle (beat 0 taken) and in the completion cycle of every beat except the last (beat k+1 taken).
- R3: A read inserts exactly one turnaround cycle after the address phase. In that cycle `bus_frame` is asserted, `bus_irdy` is negated and `bus_ad_oe` is low. In read data phases `bus_ad_oe` stays low and `bus_cbe` is 4'hF.
- R4: A data beat completes only on an edge where `bus_irdy` and `bus_trdy` are both asserted. Until then `bus_irdy` stays asserted and write data and byte enables stay unchanged. For a read, the `bus_ad_i` value sampled at the completing edge appears on `rd_data` with `rd_valid` high in the next cycle.
- R5: `bus_frame` stays asserted through the address phase, the turnaround and every data phase except the last. It is negated in the last data phase while `bus_irdy` is asserted. A `req_beats` value of 0 runs one beat.
- R6: The cycle after the last beat completes is an idle cycle: `bus_frame` and `bus_irdy` are both negated, and `done` is high for that one cycle with `aborted` low. `req_ready` is high again in the cycle after it.
- R7: Consider the first ABORT_CLKS+1 rising edges, counting from the edge that ends the address phase (ABORT_CLKS defaults to 4). If `bus_devsel` is sampled negated on every one of them, the transaction is master-aborted. The next cycle has `bus_frame` negated and `bus_irdy` asserted, and the cycle after that is idle with `done` and `aborted` high. If `bus_devsel` is seen on any of those edges, no abort is raised.
- R8: On a master-aborted read, `rd_valid` is high in the `done` cycle and `rd_data` is 32'hFFFF_FFFF.
- R9: On a master-aborted write, `wr_pop` stays low from the abort onward, the remaining beats are dropped, and no retry is attempted.
- R10: `req_ready` is high only while the block is idle. A `req_valid` held high during a transaction is ignored.
- R11: While `rst_n` is low, `bus_frame`, `bus_irdy`, `bus_ad_oe`, `bus_cbe_oe`, `done` and `rd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | block idle, request can be taken |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_addr | input | DATA_W | address placed in the address phase |
| req_cmd | input | BE_W | bus command placed in the address phase |
| req_beats | input | BEAT_W | number of data beats, 0 meaning 1 |
| wr_data | input | DATA_W | write data of the beat being offered |
| wr_be | input | BE_W | byte enables of the beat being offered |
| wr_pop | output | 1 | the offered write beat is taken at this edge |
| rd_data | output | DATA_W | returned read data |
| rd_valid | output | 1 | `rd_data` holds a returned beat |
| done | output | 1 | one-cycle end-of-transaction pulse, bus idle |
| aborted | output | 1 | with `done`: the transaction was master-aborted |
| bus_frame | output | 1 | frame strobe, asserted high |
| bus_irdy | output | 1 | initiator ready, asserted high |
| bus_ad_o | output | DATA_W | address/data driven value |
| bus_ad_oe | output | 1 | address/data output enable |
| bus_ad_i | input | DATA_W | address/data value seen on the bus |
| bus_cbe | output | BE_W | command / byte-enable value |
| bus_cbe_oe | output | 1 | command / byte-enable output enable |
| bus_devsel | input | 1 | target claimed the cycle, asserted high |
| bus_trdy | input | 1 | target ready, asserted high |

## Verification
The assertions check the strobe ordering on every cycle:
- the address phase with its drive enables;
- frame dropping only while initiator-ready is up;
- initiator-ready dropping only after frame is already gone;
- `done` appearing only on an idle bus;
- write data and byte enables held through wait states;
- no write beat taken once frame is down;
- the all-ones read value and the silent device-select in front of an aborted `done`.

Only the bench's scenarios show the rest:
- the exact cycle counts of turnaround and bursts;
- the four-versus-five-clock boundary of the abort window;
- that the right beat data reaches the bus and the right bus word reaches `rd_data`;
- that requests offered during a transaction are ignored.

// File: rtl/pcis_pkg.sv
package pcis_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_TURN  = 3'd2,
      ST_DATA  = 3'd3,
      ST_ABORT = 3'd4,
      ST_DONE  = 3'd5
   } pcis_state_e;

   function automatic logic st_active(input pcis_state_e s);
      return (s == ST_ADDR) || (s == ST_TURN) || (s == ST_DATA);
   endfunction

endpackage

// File: rtl/pcis_beat_ctr.sv
module pcis_beat_ctr #(
   parameter int MAX_BEATS = 16,
   localparam int BEAT_W = $clog2(MAX_BEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BEAT_W-1:0] load_val,
   input  logic              dec,
   output logic              last
);

   logic [BEAT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= (load_val == '0) ? BEAT_W'(1) : load_val;
      end else if (dec && (remain_q != '0)) begin
         remain_q <= remain_q - BEAT_W'(1);
      end
   end

   assign last = (remain_q <= BEAT_W'(1));

endmodule

// File: rtl/pcis_devsel_timer.sv
module pcis_devsel_timer #(
   parameter int ABORT_CLKS = 4,
   localparam int CNT_W = $clog2(ABORT_CLKS + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic devsel,
   output logic fire
);

   logic [CNT_W-1:0] silent_q;
   logic             claimed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         silent_q  <= '0;
         claimed_q <= 1'b0;
      end else if (start) begin
         silent_q  <= '0;
         claimed_q <= 1'b0;
      end else if (run && !claimed_q) begin
         if (devsel) begin
            claimed_q <= 1'b1;
         end else if (silent_q != CNT_W'(ABORT_CLKS)) begin
            silent_q <= silent_q + CNT_W'(1);
         end
      end
   end

   // The window ends at the edge that would make the silent count exceed the limit.
   assign fire = run && !claimed_q && !devsel && (silent_q == CNT_W'(ABORT_CLKS));

endmodule

// File: rtl/pcis_lane_regs.sv
module pcis_lane_regs #(
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic [DATA_W-1:0] addr,
   input  logic [BE_W-1:0]   cmd,
   input  logic              ld_beat,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   wbe,
   input  logic              ld_rdbe,
   output logic [DATA_W-1:0] ad_q,
   output logic [BE_W-1:0]   cbe_q
);

   for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
      logic [7:0] byte_q;
      logic       en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
            en_q   <= 1'b0;
         end else if (ld_addr) begin
            byte_q <= addr[ln*8 +: 8];
            en_q   <= cmd[ln];
         end else if (ld_beat) begin
            byte_q <= wdata[ln*8 +: 8];
            en_q   <= wbe[ln];
         end else if (ld_rdbe) begin
            en_q   <= 1'b1;
         end
      end

      assign ad_q[ln*8 +: 8] = byte_q;
      assign cbe_q[ln]       = en_q;
   end

endmodule

// File: rtl/pcis_rd_capture.sv
module pcis_rd_capture #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              fill,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= cap || fill;
         if (fill) begin
            rd_data <= '1;
         end else if (cap) begin
            rd_data <= ad_in;
         end
      end
   end

endmodule

// File: rtl/pcis_initiator.sv
module pcis_initiator
   import pcis_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MAX_BEATS  = 16,
   parameter int ABORT_CLKS = 4,
   localparam int BE_W   = DATA_W / 8,
   localparam int BEAT_W = $clog2(MAX_BEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_cmd,
   input  logic [BEAT_W-1:0] req_beats,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BE_W-1:0]   wr_be,
   output logic              wr_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              aborted,
   output logic              bus_frame,
   output logic              bus_irdy,
   output logic [DATA_W-1:0] bus_ad_o,
   output logic              bus_ad_oe,
   input  logic [DATA_W-1:0] bus_ad_i,
   output logic [BE_W-1:0]   bus_cbe,
   output logic              bus_cbe_oe,
   input  logic              bus_devsel,
   input  logic              bus_trdy
);

   initial begin : p_param_check
      assert (DATA_W >= 8 && (DATA_W % 8) == 0)
         else $fatal(1, "DATA_W must be a whole number of bytes");
      assert (MAX_BEATS >= 1)
         else $fatal(1, "MAX_BEATS must be at least 1");
      assert (ABORT_CLKS >= 1)
         else $fatal(1, "ABORT_CLKS must be at least 1");
   end

   pcis_state_e state_q, state_d;
   logic        write_q;
   logic        abort_q;
   logic        accept;
   logic        run;
   logic        fire;
   logic        last_beat;
   logic        beat_done;

   assign accept    = (state_q == ST_IDLE) && req_valid;
   assign run       = st_active(state_q);
   assign beat_done = (state_q == ST_DATA) && bus_trdy && !fire;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_ADDR;
         ST_ADDR:  state_d = fire ? ST_ABORT : (write_q ? ST_DATA : ST_TURN);
         ST_TURN:  state_d = fire ? ST_ABORT : ST_DATA;
         ST_DATA: begin
            if (fire) state_d = ST_ABORT;
            else if (beat_done && last_beat) state_d = ST_DONE;
         end
         ST_ABORT: state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         write_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            write_q <= req_write;
            abort_q <= 1'b0;
         end else if (fire) begin
            abort_q <= 1'b1;
         end
      end
   end

   pcis_beat_ctr #(.MAX_BEATS(MAX_BEATS)) u_beats (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (req_beats),
      .dec      (beat_done),
      .last     (last_beat)
   );

   pcis_devsel_timer #(.ABORT_CLKS(ABORT_CLKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .run    (run),
      .devsel (bus_devsel),
      .fire   (fire)
   );

   assign wr_pop = write_q && !fire &&
                   ((state_q == ST_ADDR) || (beat_done && !last_beat));

   pcis_lane_regs #(.DATA_W(DATA_W)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_addr (accept),
      .addr    (req_addr),
      .cmd     (req_cmd),
      .ld_beat (wr_pop),
      .wdata   (wr_data),
      .wbe     (wr_be),
      .ld_rdbe (!write_q && (state_q == ST_ADDR)),
      .ad_q    (bus_ad_o),
      .cbe_q   (bus_cbe)
   );

   pcis_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (beat_done && !write_q),
      .fill     ((state_q == ST_ABORT) && !write_q),
      .ad_in    (bus_ad_i),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign done       = (state_q == ST_DONE);
   assign aborted    = (state_q == ST_DONE) && abort_q;
   assign bus_frame  = (state_q == ST_ADDR) || (state_q == ST_TURN) ||
                       ((state_q == ST_DATA) && !last_beat);
   assign bus_irdy   = (state_q == ST_DATA) || (state_q == ST_ABORT);
   assign bus_ad_oe  = (state_q == ST_ADDR) || ((state_q == ST_DATA) && write_q);
   assign bus_cbe_oe = run || (state_q == ST_ABORT);

endmodule

// File: rtl/pcis_initiator_chk.sv
module pcis_initiator_chk #(
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              bus_frame,
   input logic              bus_irdy,
   input logic              bus_ad_oe,
   input logic              bus_cbe_oe,
   input logic [DATA_W-1:0] bus_ad_o,
   input logic [BE_W-1:0]   bus_cbe,
   input logic              bus_trdy,
   input logic              bus_devsel,
   input logic              wr_pop,
   input logic              done,
   input logic              aborted,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data
);

   assert_addr_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_frame) |-> bus_ad_oe && bus_cbe_oe && !bus_irdy);

   assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_irdy && bus_ad_oe && !bus_trdy) |=> ($stable(bus_ad_o) && $stable(bus_cbe)));

   assert_frame_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_frame) |-> bus_irdy);

   assert_irdy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_irdy) |-> (!bus_frame && $past(!bus_frame)));

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!bus_frame && !bus_irdy));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_abort_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && aborted) |-> ($past(bus_irdy && !bus_frame) && $past(!bus_devsel, 2)));

   assert_abort_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && aborted && rd_valid) |-> (rd_data == {DATA_W{1'b1}}));

   assert_pop_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pop |-> bus_frame);

   assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_frame && !bus_irdy && !done));

endmodule

bind pcis_initiator pcis_initiator_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .bus_frame  (bus_frame),
   .bus_irdy   (bus_irdy),
   .bus_ad_oe  (bus_ad_oe),
   .bus_cbe_oe (bus_cbe_oe),
   .bus_ad_o   (bus_ad_o),
   .bus_cbe    (bus_cbe),
   .bus_trdy   (bus_trdy),
   .bus_devsel (bus_devsel),
   .wr_pop     (wr_pop),
   .done       (done),
   .aborted    (aborted),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data)
);

// File: tb/tb_pcis_initiator.sv
module tb_pcis_initiator;

   localparam int DW = 32;
   localparam int AB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_cmd = '0;
   logic [4:0]  req_beats = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic        wr_pop;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        done;
   logic        aborted;
   logic        bus_frame;
   logic        bus_irdy;
   logic [31:0] bus_ad_o;
   logic        bus_ad_oe;
   logic [31:0] bus_ad_i = '0;
   logic [3:0]  bus_cbe;
   logic        bus_cbe_oe;
   logic        bus_devsel = 1'b0;
   logic        bus_trdy = 1'b0;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   pcis_initiator #(.DATA_W(DW), .MAX_BEATS(16), .ABORT_CLKS(AB)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_cmd(req_cmd), .req_beats(req_beats),
      .wr_data(wr_data), .wr_be(wr_be), .wr_pop(wr_pop), .rd_data(rd_data),
      .rd_valid(rd_valid), .done(done), .aborted(aborted), .bus_frame(bus_frame),
      .bus_irdy(bus_irdy), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
      .bus_cbe(bus_cbe), .bus_cbe_oe(bus_cbe_oe), .bus_devsel(bus_devsel), .bus_trdy(bus_trdy)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, act=%0d exp=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   typedef struct packed {
      logic        frame;
      logic        irdy;
      logic        oe;
      logic        chk_ad;
      logic [31:0] ad;
      logic        chk_cbe;
      logic [3:0]  cbe;
      logic        pop;
      logic        dn;
      logic        ab;
      logic        rdv;
      logic [31:0] rdd;
      logic [2:0]  ph;
   } exp_t;

   typedef struct packed {
      logic        devsel;
      logic        trdy;
      logic [31:0] adi;
      logic [31:0] wd;
      logic [3:0]  wbe;
   } stim_t;

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s %s act=%h exp=%h (cycle %0d)", req, what, act, expv, cyc);
      end
   endtask

   function automatic logic [31:0] wpat(input int k, input logic [31:0] a);
      return a ^ (32'h1111_1111 * 32'(k + 1));
   endfunction

   function automatic logic [3:0] bpat(input int k);
      return 4'((k * 5 + 3) & 15);
   endfunction

   task automatic run_txn(input bit wr, input int nreq, input int dly, input int wt,
                          input logic [31:0] addr, input logic [3:0] cmd, input bit noisy);
      exp_t  eq[$];
      stim_t sq[$];
      logic [31:0] wd[0:31];
      logic [3:0]  wb[0:31];
      int n;
      int c;
      int beat;
      int wcnt;
      int phase;
      bit ab;
      bit prev_cap;
      logic [31:0] prev_d;
      n = (nreq == 0) ? 1 : nreq;
      for (int k = 0; k < 32; k++) begin
         wd[k] = wpat(k, addr);
         wb[k] = bpat(k);
      end
      // behavioural model of the transaction, one entry per bus cycle
      c = 0; beat = 0; wcnt = 0; phase = 1; ab = 0; prev_cap = 0; prev_d = '0;
      while (phase != 0) begin
         exp_t  e;
         stim_t s;
         int    nxt;
         e = '0; s = '0;
         c = c + 1;
         s.devsel = (c > dly);
         s.adi    = 32'hC0DE_0000 + 32'(c);
         s.wd     = wd[(beat < n) ? beat : n - 1];
         s.wbe    = wb[(beat < n) ? beat : n - 1];
         e.rdv    = prev_cap;
         e.rdd    = prev_d;
         prev_cap = 0;
         e.ph     = 3'(phase);
         nxt      = phase;
         case (phase)
            1: begin
               e.frame = 1; e.oe = 1; e.chk_ad = 1; e.ad = addr;
               e.chk_cbe = 1; e.cbe = cmd; e.pop = wr;
               s.wd = wd[0]; s.wbe = wb[0];
               nxt = wr ? 3 : 2;
            end
            2: begin
               e.frame = 1; e.chk_cbe = 1; e.cbe = 4'hF;
               nxt = 3;
            end
            3: begin
               e.frame = (beat < n - 1); e.irdy = 1; e.oe = wr;
               e.chk_ad = wr; e.ad = wd[beat];
               e.chk_cbe = 1; e.cbe = wr ? wb[beat] : 4'hF;
               if ((c > dly) && (wcnt >= wt)) begin
                  s.trdy = 1;
                  e.pop = wr && (beat < n - 1);
                  if (beat < n - 1) begin
                     s.wd = wd[beat + 1]; s.wbe = wb[beat + 1];
                  end
                  if (!wr) begin
                     prev_cap = 1; prev_d = s.adi;
                  end
                  beat = beat + 1; wcnt = 0;
                  if (beat == n) nxt = 5;
               end else begin
                  wcnt = wcnt + 1;
               end
            end
            4: begin
               e.irdy = 1; nxt = 5;
            end
            default: begin
               e.dn = 1; e.ab = ab;
               if (ab && !wr) begin
                  e.rdv = 1; e.rdd = 32'hFFFF_FFFF;
               end
               nxt = 0;
            end
         endcase
         if (phase >= 1 && phase <= 3 && dly >= AB + 1 && c == AB + 1) begin
            nxt = 4; ab = 1;
         end
         eq.push_back(e);
         sq.push_back(s);
         phase = nxt;
      end

      // offer the request in an idle cycle
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = addr; req_cmd = cmd; req_beats = 5'(nreq);
      #5;
      chk(req_ready === 1'b1, "R1", "req_ready before accept", 32'(req_ready), 32'd1);

      for (int i = 0; i < eq.size(); i++) begin
         exp_t  e;
         stim_t s;
         string t_oe;
         string t_ad;
         string t_pr;
         string t_rd;
         e = eq[i]; s = sq[i];
         @(negedge clk);
         bus_devsel = s.devsel; bus_trdy = s.trdy; bus_ad_i = s.adi;
         wr_data = s.wd; wr_be = s.wbe;
         if (noisy) begin
            req_valid = 1; req_addr = 32'hDEAD_0000 + 32'(i); req_write = ~wr;
         end else begin
            req_valid = 0;
         end
         #5;
         t_oe = (e.ph == 2 || (e.ph == 3 && !wr)) ? "R3" : "R2";
         t_ad = (e.ph == 1) ? "R1" : "R2";
         t_pr = ab ? "R9" : "R2";
         t_rd = ab ? "R8" : "R4";
         chk(bus_frame === e.frame, "R5", "bus_frame", 32'(bus_frame), 32'(e.frame));
         chk(bus_irdy === e.irdy, "R4", "bus_irdy", 32'(bus_irdy), 32'(e.irdy));
         chk(bus_ad_oe === e.oe, t_oe, "bus_ad_oe", 32'(bus_ad_oe), 32'(e.oe));
         if (e.chk_ad)
            chk(bus_ad_o === e.ad, t_ad, "bus_ad_o", bus_ad_o, e.ad);
         if (e.chk_cbe)
            chk(bus_cbe === e.cbe, (e.ph == 1) ? "R1" : t_oe, "bus_cbe", 32'(bus_cbe), 32'(e.cbe));
         chk(wr_pop === e.pop, t_pr, "wr_pop", 32'(wr_pop), 32'(e.pop));
         chk(done === e.dn, "R6", "done", 32'(done), 32'(e.dn));
         chk(aborted === e.ab, "R7", "aborted", 32'(aborted), 32'(e.ab));
         chk(rd_valid === e.rdv, t_rd, "rd_valid", 32'(rd_valid), 32'(e.rdv));
         if (e.rdv)
            chk(rd_data === e.rdd, t_rd, "rd_data", rd_data, e.rdd);
         chk(req_ready === 1'b0, "R10", "req_ready while busy", 32'(req_ready), 32'd0);
      end

      @(negedge clk);
      req_valid = 0; bus_devsel = 0; bus_trdy = 0;
      #5;
      chk(req_ready === 1'b1, "R6", "req_ready after done", 32'(req_ready), 32'd1);
      chk(bus_frame === 1'b0, "R9", "bus idle after done", 32'(bus_frame), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(bus_frame === 1'b0, "R11", "frame in reset", 32'(bus_frame), 32'd0);
      chk(bus_irdy === 1'b0, "R11", "irdy in reset", 32'(bus_irdy), 32'd0);
      chk(bus_ad_oe === 1'b0 && bus_cbe_oe === 1'b0, "R11", "drive enables in reset",
          {30'd0, bus_ad_oe, bus_cbe_oe}, 32'd0);
      chk(done === 1'b0 && rd_valid === 1'b0, "R11", "done/rd_valid in reset",
          {30'd0, done, rd_valid}, 32'd0);
      chk(req_ready === 1'b1, "R11", "req_ready in reset", 32'(req_ready), 32'd1);
      rst_n = 1;
      repeat (2) @(negedge clk);

      run_txn(1, 1, 1, 0, 32'h1000_0040, 4'h7, 0);   // R2 single write
      run_txn(1, 4, 2, 1, 32'h2000_0100, 4'h7, 1);   // R2 R4 R10 burst write, wait states, busy requests
      run_txn(0, 1, 1, 0, 32'h3000_0008, 4'h6, 0);   // R3 single read
      run_txn(0, 3, 3, 2, 32'h4000_0200, 4'h6, 1);   // R3 R4 burst read with waits
      run_txn(0, 2, 4, 0, 32'h5000_0010, 4'h6, 0);   // R7 late claim, four silent edges, no abort
      run_txn(1, 3, 99, 0, 32'h6000_0300, 4'h7, 0);  // R7 R9 aborted write
      run_txn(0, 2, 99, 0, 32'h7000_0020, 4'h6, 0);  // R7 R8 aborted read
      run_txn(0, 1, 5, 0, 32'h7100_0000, 4'h6, 0);   // R7 R8 five silent edges aborts
      run_txn(1, 0, 1, 0, 32'h8000_0044, 4'h7, 0);   // R5 zero beat count runs one beat
      run_txn(1, 16, 1, 0, 32'h9000_0400, 4'h7, 0);  // R5 longest burst

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule